// File: doc/BRIEF.md
# Translation Table Batch Update Engine

This engine runs multi-entry updates of an I/O translation table. A command is either a *fill*, which writes one entry value into a run of consecutive pages, or a *list* update. A list update fetches a run of 64-bit big-endian words from system memory and writes each word into the next page. The table storage sits behind a write port that answers every entry with a status code. The list words come in through a simple read port with a valid handshake.

Each command is checked against the rules for its kind before any traffic starts. The start bus address is rounded down to the table page size, and each later entry moves one page further. The run ends at the first entry the table refuses. The engine then gives one final status and the index of the last entry that succeeded, or of the first one that failed.

Top module: `tce_batch_engine`

## Requirements
- R1: A command is taken only in a cycle where `cmd_ready` is high, which is the idle state. `cmd_valid` in any other cycle has no effect. `cmd_ready` is low while a read or a write is outstanding.
- R2: When `cmd_table_ok` is 0, the command ends with status 0x04 (parameter error) and index 0. It makes no read and no write.
- R3: A fill (`cmd_kind`=0) whose page count is greater than `cfg_table_entries` ends with status 0x04 and no write. A count equal to `cfg_table_entries` is carried out.
- R4: A list update (`cmd_kind`=1) ends with status 0x04 and no read or write when its page count is above 512 or when the list base (`cmd_arg`) has any of its 12 low bits set. A count of exactly 512 is carried out.
- R5: A page count of 0 that passes every other check ends with status 0x04, index 0 and no write.
- R6: The first write goes to `cmd_ioba` with its low `cfg_page_shift` bits cleared. Write k goes to that address plus k·2^`cfg_page_shift`.
- R7: A fill writes the value in `cmd_arg` to every page.
- R8: A list update reads entry k from list base + 8·k, one read at a time, with no write in the same cycle. Byte lane j of `mem_rdata` (bits 8j+7..8j) holds the byte at address base+8k+j. The entry is big-endian, so the value written is the lane order reversed.
- R9: `wr_req`, `wr_addr` and `wr_data` stay stable until `wr_ack`. `mem_req` and `mem_addr` stay stable until `mem_rvalid`.
- R10: When a write is acknowledged with a nonzero `wr_status`, no further read or write follows, and `done_status` carries that code.
- R11: When the run ends without a failure, `done_status` is 0x00 and `done_index` is the page count minus 1. After a failure at entry k, `done_index` is k−1 when k>0, and 0 when k=0.
- R12: `done` is high for exactly one cycle per command, and `cmd_ready` is high again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken this cycle |
| cmd_kind | input | 1 | 0 fill, 1 list update |
| cmd_table_ok | input | 1 | Target table exists and is enabled |
| cmd_ioba | input | ADDR_W | Start bus address |
| cmd_arg | input | 64 | Fill value, or list base address |
| cmd_npages | input | NPG_W | Page count |
| cfg_page_shift | input | SHIFT_W | log2 of the table page size |
| cfg_table_entries | input | ENT_W | Entry count of the table |
| mem_req | output | 1 | List read request |
| mem_addr | output | ADDR_W | List read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data, lowest address in lane 0 |
| wr_req | output | 1 | Table entry write request |
| wr_addr | output | ADDR_W | Bus address of the entry |
| wr_data | output | 64 | Entry value |
| wr_ack | input | 1 | Write accepted, status valid |
| wr_status | input | 8 | 0 success, else error code |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 8 | Final status |
| done_index | output | NPG_W | Last successful or first failing entry |

## Verification
Fills are run with small and large page shifts, with unaligned start addresses and with slow write acknowledgements. These runs separate correct rounding and striding from an engine that ignores the shift or steps by a fixed amount. List updates use entries with bytes that differ from each other, so a missing or doubled byte swap, and a wrong list stride, show up in the written data and in the fetch addresses. Each rule is probed on both sides of its limit: entry count versus count plus one, 512 versus 513, an aligned versus a misaligned list base, and a zero count. Failures injected at the first entry and at a middle entry tell apart the two branches of the index rule, and show that the run stops early.

// File: rtl/tce_batch_pkg.sv
package tce_batch_pkg;
  localparam int STAT_W      = 8;
  localparam int ENTRY_BYTES = 8;
  localparam int ENTRY_W     = 8 * ENTRY_BYTES;

  localparam logic [STAT_W-1:0] STAT_OK    = 8'h00;
  localparam logic [STAT_W-1:0] STAT_PARAM = 8'h04;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_WRITE,
    ST_DONE
  } eng_state_t;

  typedef enum logic {
    OP_FILL     = 1'b0,
    OP_INDIRECT = 1'b1
  } op_kind_t;
endpackage

// File: rtl/tce_arg_check.sv
module tce_arg_check #(
  parameter int NPG_W      = 16,
  parameter int ENT_W      = 32,
  parameter int IND_MAX    = 512,
  parameter int ALIGN_BITS = 12
) (
  input  logic                  table_ok,
  input  logic                  indirect,
  input  logic [NPG_W-1:0]      npages,
  input  logic [ENT_W-1:0]      table_entries,
  input  logic [ALIGN_BITS-1:0] list_low,
  output logic                  reject
);
  localparam int CMP_W = (NPG_W > ENT_W) ? NPG_W : ENT_W;
  localparam int CW    = (CMP_W > 32) ? CMP_W : 32;

  logic fill_bad;
  logic list_bad;
  logic zero_cnt;

  always_comb begin
    fill_bad = CW'(npages) > CW'(table_entries);
    list_bad = (CW'(npages) > CW'(IND_MAX)) || (list_low != '0);
    zero_cnt = (npages == '0);
    reject   = !table_ok || (indirect ? list_bad : fill_bad) || zero_cnt;
  end
endmodule

// File: rtl/tce_byte_swap.sv
module tce_byte_swap #(
  parameter int BYTES = 8
) (
  input  logic [8*BYTES-1:0] din,
  output logic [8*BYTES-1:0] dout
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign dout[8*b +: 8] = din[8*(BYTES-1-b) +: 8];
  end
endmodule

// File: rtl/tce_page_walker.sv
module tce_page_walker #(
  parameter int ADDR_W  = 48,
  parameter int SHIFT_W = 6,
  parameter int STEP    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [SHIFT_W-1:0] page_shift,
  input  logic [ADDR_W-1:0]  list_base,
  input  logic               advance,
  output logic [ADDR_W-1:0]  page_addr,
  output logic [ADDR_W-1:0]  list_addr
);
  logic [SHIFT_W-1:0] shift_q;
  logic [ADDR_W-1:0]  page_q;
  logic [ADDR_W-1:0]  list_q;
  logic [ADDR_W-1:0]  size_in;
  logic [ADDR_W-1:0]  stride;
  logic [ADDR_W-1:0]  page_d;
  logic [ADDR_W-1:0]  list_d;
  logic               en;

  always_comb begin
    size_in = ADDR_W'(1) << page_shift;
    stride  = ADDR_W'(1) << shift_q;
    en      = load || advance;
    if (load) begin
      page_d = start_addr & ~(size_in - ADDR_W'(1));
      list_d = list_base;
    end else begin
      page_d = page_q + stride;
      list_d = list_q + ADDR_W'(STEP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      page_q  <= '0;
      list_q  <= '0;
    end else if (en) begin
      if (load) shift_q <= page_shift;
      page_q <= page_d;
      list_q <= list_d;
    end
  end

  assign page_addr = page_q;
  assign list_addr = list_q;
endmodule

// File: rtl/tce_batch_engine.sv
module tce_batch_engine
  import tce_batch_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int NPG_W      = 16,
  parameter int ENT_W      = 32,
  parameter int SHIFT_W    = 6,
  parameter int IND_MAX    = 512,
  parameter int ALIGN_BITS = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_kind,
  input  logic               cmd_table_ok,
  input  logic [ADDR_W-1:0]  cmd_ioba,
  input  logic [63:0]        cmd_arg,
  input  logic [NPG_W-1:0]   cmd_npages,
  input  logic [SHIFT_W-1:0] cfg_page_shift,
  input  logic [ENT_W-1:0]   cfg_table_entries,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_rvalid,
  input  logic [63:0]        mem_rdata,
  output logic               wr_req,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [63:0]        wr_data,
  input  logic               wr_ack,
  input  logic [7:0]         wr_status,
  output logic               done,
  output logic [7:0]         done_status,
  output logic [NPG_W-1:0]   done_index
);
  eng_state_t         state_q, state_d;
  op_kind_t           kind_q;
  logic               tbl_ok_q;
  logic [NPG_W-1:0]   npg_q;
  logic [ENTRY_W-1:0] arg_q;
  logic [NPG_W-1:0]   cnt_q;
  logic [ENTRY_W-1:0] data_q, data_d;
  logic [STAT_W-1:0]  stat_q, stat_d;
  logic               data_en, stat_en;

  logic               accept;
  logic               reject;
  logic               wr_done;
  logic               wr_good;
  logic               last;
  logic [ENTRY_W-1:0] swapped;

  tce_arg_check #(
    .NPG_W(NPG_W), .ENT_W(ENT_W), .IND_MAX(IND_MAX), .ALIGN_BITS(ALIGN_BITS)
  ) u_check (
    .table_ok      (tbl_ok_q),
    .indirect      (kind_q == OP_INDIRECT),
    .npages        (npg_q),
    .table_entries (cfg_table_entries),
    .list_low      (arg_q[ALIGN_BITS-1:0]),
    .reject        (reject)
  );

  tce_page_walker #(
    .ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W), .STEP(ENTRY_BYTES)
  ) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .start_addr (cmd_ioba),
    .page_shift (cfg_page_shift),
    .list_base  (cmd_arg[ADDR_W-1:0]),
    .advance    (wr_good),
    .page_addr  (wr_addr),
    .list_addr  (mem_addr)
  );

  tce_byte_swap #(.BYTES(ENTRY_BYTES)) u_swap (
    .din  (mem_rdata),
    .dout (swapped)
  );

  always_comb begin
    accept  = (state_q == ST_IDLE) && cmd_valid;
    wr_done = (state_q == ST_WRITE) && wr_ack;
    wr_good = wr_done && (wr_status == STAT_OK);
    last    = (cnt_q + NPG_W'(1)) == npg_q;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cmd_valid) state_d = ST_CHECK;
      ST_CHECK: begin
        if (reject)                     state_d = ST_DONE;
        else if (kind_q == OP_INDIRECT) state_d = ST_FETCH;
        else                            state_d = ST_WRITE;
      end
      ST_FETCH: if (mem_rvalid) state_d = ST_WRITE;
      ST_WRITE: begin
        if (wr_done) begin
          if (!wr_good || last)           state_d = ST_DONE;
          else if (kind_q == OP_INDIRECT) state_d = ST_FETCH;
          else                            state_d = ST_WRITE;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    data_en = 1'b0;
    data_d  = data_q;
    if (state_q == ST_CHECK) begin
      data_en = 1'b1;
      data_d  = arg_q;
    end else if (state_q == ST_FETCH && mem_rvalid) begin
      data_en = 1'b1;
      data_d  = swapped;
    end
    stat_en = 1'b0;
    stat_d  = stat_q;
    if (state_q == ST_CHECK) begin
      stat_en = 1'b1;
      stat_d  = reject ? STAT_PARAM : STAT_OK;
    end else if (wr_done && !wr_good) begin
      stat_en = 1'b1;
      stat_d  = wr_status;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      kind_q   <= OP_FILL;
      tbl_ok_q <= 1'b0;
      npg_q    <= '0;
      arg_q    <= '0;
      cnt_q    <= '0;
      data_q   <= '0;
      stat_q   <= STAT_OK;
    end else begin
      state_q <= state_d;
      if (accept) begin
        kind_q   <= op_kind_t'(cmd_kind);
        tbl_ok_q <= cmd_table_ok;
        npg_q    <= cmd_npages;
        arg_q    <= cmd_arg;
      end
      if (accept)       cnt_q <= '0;
      else if (wr_good) cnt_q <= cnt_q + NPG_W'(1);
      if (data_en) data_q <= data_d;
      if (stat_en) stat_q <= stat_d;
    end
  end

  assign cmd_ready   = (state_q == ST_IDLE);
  assign mem_req     = (state_q == ST_FETCH);
  assign wr_req      = (state_q == ST_WRITE);
  assign wr_data     = data_q;
  assign done        = (state_q == ST_DONE);
  assign done_status = stat_q;
  assign done_index  = (cnt_q == '0) ? '0 : cnt_q - NPG_W'(1);
endmodule

// File: rtl/tce_batch_checks.sv
module tce_batch_checks #(
  parameter int ADDR_W  = 48,
  parameter int SHIFT_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_ready,
  input logic [SHIFT_W-1:0] cfg_page_shift,
  input logic               mem_req,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic               mem_rvalid,
  input logic               wr_req,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [63:0]        wr_data,
  input logic               wr_ack,
  input logic [7:0]         wr_status,
  input logic               done,
  input logic [7:0]         done_status
);
  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req || mem_req) |-> !cmd_ready);

  assert_page_stride_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_req && wr_ack && wr_status == 8'h00) && wr_req)
      |-> wr_addr == $past(wr_addr) + (ADDR_W'(1) << cfg_page_shift));

  assert_one_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && mem_req));

  assert_write_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  assert_stop_on_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_ack && wr_status != 8'h00)
      |=> (done && !wr_req && !mem_req && done_status == $past(wr_status)));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));
endmodule

bind tce_batch_engine tce_batch_checks #(
  .ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_ready      (cmd_ready),
  .cfg_page_shift (cfg_page_shift),
  .mem_req        (mem_req),
  .mem_addr       (mem_addr),
  .mem_rvalid     (mem_rvalid),
  .wr_req         (wr_req),
  .wr_addr        (wr_addr),
  .wr_data        (wr_data),
  .wr_ack         (wr_ack),
  .wr_status      (wr_status),
  .done           (done),
  .done_status    (done_status)
);

// File: tb/sim_tce_batch_engine.sv
`timescale 1ns/1ps
module sim_tce_batch_engine;
  localparam int AW = 48;
  localparam int NW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_kind = 1'b0;
  logic          cmd_table_ok = 1'b1;
  logic [AW-1:0] cmd_ioba = '0;
  logic [63:0]   cmd_arg = '0;
  logic [NW-1:0] cmd_npages = '0;
  logic [5:0]    cfg_page_shift = 6'd12;
  logic [31:0]   cfg_table_entries = 32'd100;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_rvalid = 1'b0;
  logic [63:0]   mem_rdata = '0;
  logic          wr_req;
  logic [AW-1:0] wr_addr;
  logic [63:0]   wr_data;
  logic          wr_ack = 1'b0;
  logic [7:0]    wr_status = '0;
  logic          done;
  logic [7:0]    done_status;
  logic [NW-1:0] done_index;

  tce_batch_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_table_ok(cmd_table_ok), .cmd_ioba(cmd_ioba),
    .cmd_arg(cmd_arg), .cmd_npages(cmd_npages), .cfg_page_shift(cfg_page_shift),
    .cfg_table_entries(cfg_table_entries), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack), .wr_status(wr_status),
    .done(done), .done_status(done_status), .done_index(done_index)
  );

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  logic [AW-1:0] wlog_a [0:63];
  logic [63:0]   wlog_d [0:63];
  logic [AW-1:0] rlog_a [0:63];
  int wr_n = 0, rd_n = 0, done_n = 0;
  int wr_lat = 0, rd_lat = 0, wr_wait = 0, rd_wait = 0;
  int fail_at = -1;
  logic [7:0] fail_code = 8'h00;
  logic [AW-1:0] list_base = '0;

  function automatic logic [63:0] entry_val(int k);
    return {16'hBE00 ^ 16'(k), 32'h1357_9BDF, 16'(k) + 16'h0102};
  endfunction

  function automatic logic [63:0] bswap(logic [63:0] v);
    logic [63:0] r;
    for (int j = 0; j < 8; j++) r[8*j +: 8] = v[8*(7-j) +: 8];
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // table and memory models, driven away from the active edge
  always @(negedge clk) begin
    if (done) done_n++;
    if (wr_req) begin
      if (wr_wait < wr_lat) begin
        wr_wait++;
        wr_ack = 1'b0;
      end else begin
        wr_wait = 0;
        wr_ack = 1'b1;
        wr_status = (wr_n == fail_at) ? fail_code : 8'h00;
        if (wr_n < 64) begin
          wlog_a[wr_n] = wr_addr;
          wlog_d[wr_n] = wr_data;
        end
        wr_n++;
      end
    end else begin
      wr_ack = 1'b0;
      wr_wait = 0;
    end
    if (mem_req) begin
      if (rd_wait < rd_lat) begin
        rd_wait++;
        mem_rvalid = 1'b0;
      end else begin
        rd_wait = 0;
        mem_rvalid = 1'b1;
        mem_rdata = bswap(entry_val(int'((mem_addr - list_base) >> 3)));
        if (rd_n < 64) rlog_a[rd_n] = mem_addr;
        rd_n++;
      end
    end else begin
      mem_rvalid = 1'b0;
      rd_wait = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  task automatic run_cmd(input logic kind, input logic ok, input logic [AW-1:0] ioba,
                         input logic [63:0] arg, input logic [NW-1:0] npg,
                         output logic [7:0] st, output logic [NW-1:0] idx);
    int t;
    wr_n = 0; rd_n = 0; done_n = 0;
    list_base = arg[AW-1:0];
    @(negedge clk);
    cmd_kind = kind; cmd_table_ok = ok; cmd_ioba = ioba;
    cmd_arg = arg; cmd_npages = npg; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL R12 no done: actual=0 expected=1");
    end
    st = done_status;
    idx = done_index;
    @(negedge clk);
    check("R12", "done falls", done, 0);
    check("R12", "ready again", cmd_ready, 1);
  endtask

  task automatic t_reset;
    check("R1", "ready after reset", cmd_ready, 1);
    check("R12", "done after reset", done, 0);
    check("R9", "no write after reset", wr_req, 0);
    check("R8", "no read after reset", mem_req, 0);
  endtask

  task automatic t_fill_basic;
    logic [7:0] st; logic [NW-1:0] idx;
    cfg_page_shift = 6'd12; cfg_table_entries = 32'd100; wr_lat = 0;
    run_cmd(1'b0, 1'b1, 48'h0001_2345, 64'hDEAD_BEEF_0000_0003, 16'd4, st, idx);
    check("R11", "fill status", st, 8'h00);
    check("R11", "fill index", idx, 3);
    check("R7", "fill writes", wr_n, 4);
    check("R8", "fill reads", rd_n, 0);
    for (int k = 0; k < 4; k++) begin
      check("R6", "fill addr", wlog_a[k], 48'h0001_2000 + 48'(k) * 48'h1000);
      check("R7", "fill data", wlog_d[k], 64'hDEAD_BEEF_0000_0003);
    end
  endtask

  task automatic t_fill_bigpage;
    logic [7:0] st; logic [NW-1:0] idx;
    cfg_page_shift = 6'd16; wr_lat = 2;
    run_cmd(1'b0, 1'b1, 48'h0003_0000_ABCD, 64'h0000_0000_0F0F_0001, 16'd3, st, idx);
    check("R11", "bigpage status", st, 8'h00);
    check("R11", "bigpage index", idx, 2);
    for (int k = 0; k < 3; k++)
      check("R6", "bigpage addr", wlog_a[k], 48'h0003_0000_0000 + 48'(k) * 48'h1_0000);
    cfg_page_shift = 6'd12; wr_lat = 0;
  endtask

  task automatic t_fill_limit;
    logic [7:0] st; logic [NW-1:0] idx;
    cfg_table_entries = 32'd8;
    run_cmd(1'b0, 1'b1, 48'h0, 64'h1, 16'd9, st, idx);
    check("R3", "over count status", st, 8'h04);
    check("R3", "over count writes", wr_n, 0);
    run_cmd(1'b0, 1'b1, 48'h0, 64'h1, 16'd8, st, idx);
    check("R3", "equal count status", st, 8'h00);
    check("R3", "equal count writes", wr_n, 8);
    cfg_table_entries = 32'd100;
  endtask

  task automatic t_zero_and_table;
    logic [7:0] st; logic [NW-1:0] idx;
    run_cmd(1'b0, 1'b1, 48'h4000, 64'h1, 16'd0, st, idx);
    check("R5", "zero status", st, 8'h04);
    check("R5", "zero index", idx, 0);
    check("R5", "zero writes", wr_n, 0);
    run_cmd(1'b1, 1'b1, 48'h4000, 64'h7000, 16'd0, st, idx);
    check("R5", "zero list reads", rd_n, 0);
    run_cmd(1'b0, 1'b0, 48'h4000, 64'h1, 16'd2, st, idx);
    check("R2", "bad table status", st, 8'h04);
    check("R2", "bad table index", idx, 0);
    check("R2", "bad table writes", wr_n, 0);
    run_cmd(1'b1, 1'b0, 48'h4000, 64'h7000, 16'd2, st, idx);
    check("R2", "bad table reads", rd_n, 0);
  endtask

  task automatic t_list_basic;
    logic [7:0] st; logic [NW-1:0] idx;
    rd_lat = 1; wr_lat = 1;
    run_cmd(1'b1, 1'b1, 48'h0000_8123, 64'h5000, 16'd5, st, idx);
    check("R11", "list status", st, 8'h00);
    check("R11", "list index", idx, 4);
    check("R8", "list reads", rd_n, 5);
    for (int k = 0; k < 5; k++) begin
      check("R8", "list fetch addr", rlog_a[k], 48'h5000 + 48'(8 * k));
      check("R8", "list data", wlog_d[k], entry_val(k));
      check("R6", "list addr", wlog_a[k], 48'h8000 + 48'(k) * 48'h1000);
    end
    rd_lat = 0; wr_lat = 0;
  endtask

  task automatic t_list_limits;
    logic [7:0] st; logic [NW-1:0] idx;
    run_cmd(1'b1, 1'b1, 48'h0, 64'h5008, 16'd2, st, idx);
    check("R4", "misaligned status", st, 8'h04);
    check("R4", "misaligned reads", rd_n, 0);
    run_cmd(1'b1, 1'b1, 48'h0, 64'h6000, 16'd513, st, idx);
    check("R4", "513 status", st, 8'h04);
    check("R4", "513 writes", wr_n, 0);
    run_cmd(1'b1, 1'b1, 48'h0, 64'h6000, 16'd512, st, idx);
    check("R4", "512 status", st, 8'h00);
    check("R4", "512 writes", wr_n, 512);
    check("R11", "512 index", idx, 511);
  endtask

  task automatic t_fail_paths;
    logic [7:0] st; logic [NW-1:0] idx;
    fail_at = 2; fail_code = 8'h20;
    run_cmd(1'b0, 1'b1, 48'h0, 64'h55, 16'd6, st, idx);
    check("R10", "mid fail status", st, 8'h20);
    check("R10", "mid fail writes", wr_n, 3);
    check("R11", "mid fail index", idx, 1);
    fail_at = 0; fail_code = 8'h05;
    run_cmd(1'b0, 1'b1, 48'h0, 64'h55, 16'd6, st, idx);
    check("R10", "first fail status", st, 8'h05);
    check("R10", "first fail writes", wr_n, 1);
    check("R11", "first fail index", idx, 0);
    fail_at = 3; fail_code = 8'h07;
    run_cmd(1'b1, 1'b1, 48'h0, 64'h9000, 16'd6, st, idx);
    check("R10", "list fail status", st, 8'h07);
    check("R10", "list fail reads", rd_n, 4);
    check("R11", "list fail index", idx, 2);
    fail_at = -1;
  endtask

  task automatic t_busy_ignore;
    int t;
    wr_n = 0; rd_n = 0; done_n = 0; wr_lat = 3;
    @(negedge clk);
    cmd_kind = 1'b0; cmd_table_ok = 1'b1; cmd_ioba = 48'h2000;
    cmd_arg = 64'hAB; cmd_npages = 16'd4; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_npages = 16'd2; cmd_arg = 64'hCD;
    @(negedge clk);
    check("R1", "busy not ready", cmd_ready, 0);
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    t = 0;
    while (!done && t < 200) begin
      @(negedge clk);
      t++;
    end
    repeat (8) @(negedge clk);
    check("R1", "ignored cmd writes", wr_n, 4);
    check("R1", "ignored cmd data", wlog_d[3], 64'hAB);
    check("R12", "single done pulse", done_n, 1);
    wr_lat = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_basic();
    t_fill_bigpage();
    t_fill_limit();
    t_zero_and_table();
    t_list_basic();
    t_list_limits();
    t_fail_paths();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule